// File: doc/BRIEF.md
# Crosspoint Switch State Array

This block stores the open/closed state of a 16-row by 8-column switch matrix, one bit per crosspoint, and presents all 128 bits as a single vector to the switch drivers. A host changes one crosspoint at a time. It presents a row code, a column code and a data bit, then raises the strobe while the chip select is high. A data value of 1 closes the addressed switch and 0 opens it. A master clear opens every switch at once.

All control pins are sampled on the system clock. Every clock edge at which strobe and select are both high and clear is low writes the data bit into the addressed cell. While the strobe stays high, the cell therefore follows the data input. The value sampled on the last edge before the strobe falls is the one that is kept. The row code goes through a fixed non-linear decode before it selects a physical row. Several arrays can share the address, data and strobe lines, each gated by its own select, to build a larger matrix.

Top module: `xpt_state_array`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `sw_state` is all zeros.
- R2: A write (`stb`=1, `sel`=1, `clr`=0 at a clock edge) with `din`=1 sets bit `col_code*16 + physical_row` of `sw_state`, visible after that edge.
- R3: A write with `din`=0 clears the addressed bit.
- R4: Row codes map to physical rows as follows: 0–5 map to 0–5, 6 maps to 12, 7 maps to 13, 8–13 map to 6–11, 14 maps to 14 and 15 maps to 15.
- R5: Column codes 0–7 select columns 0–7 directly, and the column is the upper index field (bit position = column×16 + physical row).
- R6: A clock edge with `stb` low leaves `sw_state` unchanged, whatever the address and data are.
- R7: A clock edge with `sel` low leaves `sw_state` unchanged, even with `stb` high.
- R8: `clr` high at a clock edge makes `sw_state` all zeros after that edge, and this overrides a write in the same cycle.
- R9: While the strobe stays high over several edges, the addressed bit follows `din` on each edge. The value sampled on the last high edge is kept after the strobe falls.
- R10: A write changes at most one bit, and other bits keep their values, so any combination of switches may be closed at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset; opens all switches |
| row_code | input | 4 | Row code (goes through the row decode) |
| col_code | input | 3 | Column code |
| din | input | 1 | 1 closes the addressed switch, 0 opens it |
| stb | input | 1 | Strobe, active high |
| sel | input | 1 | Array select, active high |
| clr | input | 1 | Master clear, active high; opens every switch |
| sw_state | output | 128 | Switch states, bit = column×16 + physical row |

## Verification
All 16 row codes are written into one column. This separates the non-linear row decode from a straight binary decode, because codes 6–13 land on different bits under the two schemes. Writes to one row code across all eight columns show that the column is the upper index field. Accumulated closures followed by selective openings show that a write touches only the addressed bit. Strobes with the select low, edges with the strobe low, a strobe held high while the data toggles, and a clear that coincides with a write separate the gating, the follow-then-hold behaviour and the priority of the clear.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
   localparam int unsigned XPT_ROWS   = 16;
   localparam int unsigned XPT_COLS   = 8;
   localparam int unsigned XPT_ROW_AW = 4;
   localparam int unsigned XPT_COL_AW = 3;

   typedef enum logic [0:0] {
      ROW_LINEAR    = 1'b0,
      ROW_SCRAMBLED = 1'b1
   } row_decode_e;
endpackage

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
   parameter int unsigned ROW_AW = 4,
   parameter int unsigned COL_AW = 3,
   parameter bit          IN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_AW-1:0] row_i,
   input  logic [COL_AW-1:0] col_i,
   input  logic              din_i,
   input  logic              stb_i,
   input  logic              sel_i,
   input  logic              clr_i,
   output logic [ROW_AW-1:0] row_o,
   output logic [COL_AW-1:0] col_o,
   output logic              din_o,
   output logic              we_o,
   output logic              clr_o
);
   logic we_raw;

   // a write needs strobe and select, and is blocked by clear
   assign we_raw = stb_i & sel_i & ~clr_i;

   generate
      if (IN_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_o <= '0;
               col_o <= '0;
               din_o <= 1'b0;
               we_o  <= 1'b0;
               clr_o <= 1'b0;
            end else begin
               row_o <= row_i;
               col_o <= col_i;
               din_o <= din_i;
               we_o  <= we_raw;
               clr_o <= clr_i;
            end
         end
      end else begin : g_direct
         assign row_o = row_i;
         assign col_o = col_i;
         assign din_o = din_i;
         assign we_o  = we_raw;
         assign clr_o = clr_i;
      end
   endgenerate
endmodule

// File: rtl/xpt_row_map.sv
module xpt_row_map
   import xpt_pkg::*;
#(
   parameter int unsigned ROWS   = 16,
   parameter int unsigned ROW_AW = 4,
   parameter row_decode_e MODE   = ROW_SCRAMBLED
) (
   input  logic [ROW_AW-1:0] code_i,
   output logic [ROW_AW-1:0] row_o
);
   generate
      if (ROWS != (1 << ROW_AW)) begin : g_bad_rows
         $error("xpt_row_map: ROWS must equal 2**ROW_AW");
      end
      if (MODE == ROW_SCRAMBLED && ROWS != 16) begin : g_bad_scr
         $error("xpt_row_map: scrambled decode needs 16 rows");
      end

      if (MODE == ROW_SCRAMBLED) begin : g_scr
         // codes 6..7 jump up to rows 12..13, codes 8..13 slide down to 6..11
         always_comb begin
            if (code_i >= ROW_AW'(6) && code_i <= ROW_AW'(7)) begin
               row_o = code_i + ROW_AW'(6);
            end else if (code_i >= ROW_AW'(8) && code_i <= ROW_AW'(13)) begin
               row_o = code_i - ROW_AW'(2);
            end else begin
               row_o = code_i;
            end
         end

         // R4: the decode keeps the edge codes and moves only the middle band
         always_comb begin
            if (code_i < ROW_AW'(6) || code_i > ROW_AW'(13)) begin
               a_r4_edge_identity: assert (row_o == code_i);
            end else begin
               a_r4_band_moved: assert (row_o != code_i);
            end
         end
      end else begin : g_lin
         assign row_o = code_i;
      end
   endgenerate
endmodule

// File: rtl/xpt_cell_bank.sv
module xpt_cell_bank #(
   parameter int unsigned CELLS = 128,
   parameter int unsigned IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic             clr_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             din_i,
   output logic [CELLS-1:0] state_o
);
   generate
      if (CELLS > (1 << IDX_W)) begin : g_bad_idx
         $error("xpt_cell_bank: IDX_W too narrow for CELLS");
      end

      for (genvar c = 0; c < CELLS; c++) begin : g_cell
         logic hit;
         assign hit = we_i && (idx_i == IDX_W'(c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state_o[c] <= 1'b0;
            end else if (clr_i) begin
               state_o[c] <= 1'b0;
            end else if (hit) begin
               state_o[c] <= din_i;
            end
         end
      end
   endgenerate

   // R2 / R3: the addressed cell takes the data bit
   a_r2_write_value: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !clr_i) |=> (state_o[$past(idx_i)] == $past(din_i)));

   // R8: a clear empties every cell
   a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (state_o == '0));

   // R10: at most one cell changes per cycle outside a clear
   a_r10_single_change: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ($countones(state_o ^ $past(state_o)) <= 1));
endmodule

// File: rtl/xpt_state_array.sv
module xpt_state_array
   import xpt_pkg::*;
#(
   parameter int unsigned ROWS     = XPT_ROWS,
   parameter int unsigned COLS     = XPT_COLS,
   parameter int unsigned ROW_AW   = XPT_ROW_AW,
   parameter int unsigned COL_AW   = XPT_COL_AW,
   parameter row_decode_e ROW_MODE = ROW_SCRAMBLED,
   parameter bit          IN_REG   = 1'b0,
   localparam int unsigned CELLS   = ROWS * COLS,
   localparam int unsigned IDX_W   = ROW_AW + COL_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_AW-1:0] row_code,
   input  logic [COL_AW-1:0] col_code,
   input  logic              din,
   input  logic              stb,
   input  logic              sel,
   input  logic              clr,
   output logic [CELLS-1:0]  sw_state
);
   generate
      if (COLS != (1 << COL_AW)) begin : g_bad_cols
         $error("xpt_state_array: COLS must equal 2**COL_AW");
      end
   endgenerate

   logic [ROW_AW-1:0] row_q;
   logic [COL_AW-1:0] col_q;
   logic              din_q;
   logic              we;
   logic              clr_q;
   logic [ROW_AW-1:0] phys_row;
   logic [IDX_W-1:0]  cell_idx;

   xpt_ctrl #(
      .ROW_AW (ROW_AW),
      .COL_AW (COL_AW),
      .IN_REG (IN_REG)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .row_i (row_code),
      .col_i (col_code),
      .din_i (din),
      .stb_i (stb),
      .sel_i (sel),
      .clr_i (clr),
      .row_o (row_q),
      .col_o (col_q),
      .din_o (din_q),
      .we_o  (we),
      .clr_o (clr_q)
   );

   xpt_row_map #(
      .ROWS   (ROWS),
      .ROW_AW (ROW_AW),
      .MODE   (ROW_MODE)
   ) u_row_map (
      .code_i (row_q),
      .row_o  (phys_row)
   );

   // column is the upper field: index = column * ROWS + physical row
   assign cell_idx = {col_q, phys_row};

   xpt_cell_bank #(
      .CELLS (CELLS),
      .IDX_W (IDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .clr_i   (clr_q),
      .idx_i   (cell_idx),
      .din_i   (din_q),
      .state_o (sw_state)
   );

   generate
      if (!IN_REG) begin : g_port_checks
         // R6 / R7: no strobe, or no select, means no change
         a_r6_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ((!stb || !sel) && !clr) |=> $stable(sw_state));

         // R8: clear wins over a strobe in the same cycle
         a_r8_clear_priority: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && stb && sel) |=> (sw_state == '0));
      end
   endgenerate
endmodule

// File: tb/test_xpt_state_array.sv
module test_xpt_state_array;
   typedef struct {
      logic [127:0] exp;
      string        req;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   row_code = '0;
   logic [2:0]   col_code = '0;
   logic         din = 1'b0;
   logic         stb = 1'b0;
   logic         sel = 1'b0;
   logic         clr = 1'b0;
   logic [127:0] sw_state;

   int    n_checks = 0;
   int    n_errors = 0;
   item_t sb_q[$];
   logic [127:0] model = '0;

   always #4 clk = ~clk;

   xpt_state_array i_xpt_state_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_code (row_code),
      .col_code (col_code),
      .din      (din),
      .stb      (stb),
      .sel      (sel),
      .clr      (clr),
      .sw_state (sw_state)
   );

   function automatic int phys_of(input int code);
      if (code == 6 || code == 7) return code + 6;
      if (code >= 8 && code <= 13) return code - 2;
      return code;
   endfunction

   task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus, predict the state after the next edge
   task automatic step(input int rc, input int cc, input logic d, input logic s,
                       input logic cs, input logic c, input string req);
      item_t it;
      @(negedge clk);
      row_code = 4'(rc);
      col_code = 3'(cc);
      din = d;
      stb = s;
      sel = cs;
      clr = c;
      if (c) model = '0;
      else if (s && cs) model[cc*16 + phys_of(rc)] = d;
      it.exp = model;
      it.req = req;
      sb_q.push_back(it);
   endtask

   // monitor: compare after each edge that follows a driven cycle
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check(sw_state, it.exp, it.req);
      end
   end

   initial begin
      #1_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(sw_state, '0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(sw_state, '0, "R1 after reset");

      // R2: close X-code 3 / column 4, then code 12 / column 7 (both held, R10)
      step(3, 4, 1'b1, 1'b1, 1'b1, 1'b0, "R2 close code3 col4");
      step(12, 7, 1'b1, 1'b1, 1'b1, 1'b0, "R10 second closure keeps first");
      step(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 idle");

      // R4: every row code into column 1
      for (int k = 0; k < 16; k++) begin
         step(k, 1, 1'b1, 1'b1, 1'b1, 1'b0, "R4 row decode");
      end

      // R3: open the first closure
      step(3, 4, 1'b0, 1'b1, 1'b1, 1'b0, "R3 open code3 col4");
      step(3, 4, 1'b0, 1'b0, 1'b1, 1'b0, "R3 strobe off");

      // R6: strobe low with data high at a fresh address
      step(5, 2, 1'b1, 1'b0, 1'b1, 1'b0, "R6 strobe low ignored");
      // R7: select low with strobe high
      step(5, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R7 select low ignored");
      step(9, 6, 1'b1, 1'b1, 1'b0, 1'b0, "R7 select low ignored");

      // R9: strobe held high, data toggles, final value kept
      step(7, 3, 1'b1, 1'b1, 1'b1, 1'b0, "R9 follow 1");
      step(7, 3, 1'b0, 1'b1, 1'b1, 1'b0, "R9 follow 0");
      step(7, 3, 1'b1, 1'b1, 1'b1, 1'b0, "R9 follow 1 again");
      step(7, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R9 kept after strobe falls");
      step(7, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R9 still kept");

      // R5: code 15 across all columns
      for (int cc = 0; cc < 8; cc++) begin
         step(15, cc, 1'b1, 1'b1, 1'b1, 1'b0, "R5 column field");
      end
      step(8, 5, 1'b1, 1'b1, 1'b1, 1'b0, "R5 code8 col5");

      // R8: clear coinciding with a write
      step(10, 0, 1'b1, 1'b1, 1'b1, 1'b1, "R8 clear overrides write");
      step(10, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 stays clear");
      step(13, 6, 1'b1, 1'b1, 1'b1, 1'b0, "R2 close code13 col6");
      step(6, 0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 code6 col0");
      step(0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 clear alone");
      step(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 idle after clear");

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule